// File: doc/BRIEF.md
# Bit-Matrix Transpose and Multiply Unit

This unit reads each 64-bit operand as an 8x8 matrix of bits. Byte r of an operand is row r, and bit m of that byte is column m. A 2-bit operation select picks one of three functions. The first is a transpose of operand A. The second is a product of A and B over GF(2), where each term is an AND and the terms are summed by XOR. The third is a boolean product, where the same AND terms are summed by OR. The select value 11 gives a zero result. The unit is meant to sit in the execute stage of a datapath, next to the other bit-manipulation functions.

The arithmetic is purely combinational. The parameter `REG_OUT` decides how the result leaves the unit. With `REG_OUT = 1`, a two-state output machine captures the result. Its states are `ST_IDLE` (no valid result) and `ST_HOLD` (a result is valid). Its transitions are:

- `ST_IDLE -> ST_HOLD` when `in_valid` is high.
- `ST_HOLD -> ST_HOLD` when `in_valid` is high.
- `ST_HOLD -> ST_IDLE` when `in_valid` is low.
- `ST_IDLE -> ST_IDLE` when `in_valid` is low.

A synchronous reset forces `ST_IDLE` and clears the result register. With `REG_OUT = 0`, the result and `out_valid` follow the inputs directly.

Top module: `bmx_unit`

## Requirements
- R1: With op_sel = 00 (transpose), result bit (j*8 + k) equals opnd_a bit (k*8 + j), for all j and k in 0..7.
- R2: With op_sel = 00, the value of opnd_b has no effect on the result.
- R3: With op_sel = 01 (XOR product), result bit (r*8 + c) is the XOR over m = 0..7 of opnd_a[r*8+m] AND opnd_b[m*8+c].
- R4: With op_sel = 10 (OR product), result bit (r*8 + c) is the OR over m = 0..7 of opnd_a[r*8+m] AND opnd_b[m*8+c].
- R5: With op_sel = 11, the result is all zeros, whatever the operands are.
- R6: With REG_OUT = 1, a cycle in which in_valid is high is followed, one clock later, by out_valid high and by result holding the function of the inputs from that cycle.
- R7: With REG_OUT = 1, a cycle in which in_valid is low is followed by out_valid low, and result keeps its previous value even if the inputs change.
- R8: With REG_OUT = 1, a synchronous reset clears result to zero and out_valid to 0 at the next clock edge.
- R9: With REG_OUT = 0, result is the combinational function of the current inputs, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operands and select are valid this cycle |
| op_sel | input | 2 | 00 transpose, 01 XOR product, 10 OR product, 11 zero |
| opnd_a | input | 64 | First matrix: the left factor, or the matrix that is transposed |
| opnd_b | input | 64 | Second matrix: the right factor of a product |
| result | output | 64 | Result matrix |
| out_valid | output | 1 | The result is valid |

## Verification
The bench builds two instances side by side.

- The first uses the defaults, ROWS = 8 and REG_OUT = 1. It exercises the output state machine: capture one cycle after in_valid, holding while in_valid is low, and reset in the middle of a result.
- The second uses ROWS = 8 and REG_OUT = 0. It checks the same function with no register in the path. Because both instances see the same stimulus, every operation can also be compared between the registered and the direct path.

The vectors are chosen for their structure: the identity, single set bits, full rows, full columns and the all-ones matrix. Together they expose swapped row and column indices and a wrong reduction (XOR against OR). Random operands are then checked against a bench model written from the requirement formulas.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    typedef enum logic [1:0] {
        OP_FLIP = 2'b00,
        OP_XMUL = 2'b01,
        OP_OMUL = 2'b10,
        OP_NONE = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ost_e;
endpackage

// File: rtl/bmx_flip.sv
module bmx_flip #(
    parameter int ROWS = 8,
    localparam int W = ROWS * ROWS
) (
    input  logic [W-1:0] mat_in,
    output logic [W-1:0] mat_out
);
    for (genvar k = 0; k < ROWS; k++) begin : g_row
        for (genvar j = 0; j < ROWS; j++) begin : g_col
            assign mat_out[j*ROWS + k] = mat_in[k*ROWS + j];
        end
    end
endmodule

// File: rtl/bmx_mul.sv
module bmx_mul #(
    parameter int ROWS = 8,
    localparam int W = ROWS * ROWS
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] prod_xor,
    output logic [W-1:0] prod_or
);
    logic [W-1:0] rhs_t;

    bmx_flip #(.ROWS(ROWS)) u_rhs_flip (
        .mat_in (rhs),
        .mat_out(rhs_t)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < ROWS; c++) begin : g_c
            logic [ROWS-1:0] terms;
            assign terms = lhs[r*ROWS +: ROWS] & rhs_t[c*ROWS +: ROWS];
            assign prod_xor[r*ROWS + c] = ^terms;
            assign prod_or[r*ROWS + c]  = |terms;
        end
    end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int W = ROWS * ROWS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         out_valid
);
    logic [W-1:0] flip_a;
    logic [W-1:0] px, po;
    logic [W-1:0] comb_res;
    op_e          op;

    assign op = op_e'(op_sel);

    bmx_flip #(.ROWS(ROWS)) u_flip_a (
        .mat_in (opnd_a),
        .mat_out(flip_a)
    );

    bmx_mul #(.ROWS(ROWS)) u_mul (
        .lhs     (opnd_a),
        .rhs     (opnd_b),
        .prod_xor(px),
        .prod_or (po)
    );

    always_comb begin
        unique case (op)
            OP_FLIP: comb_res = flip_a;
            OP_XMUL: comb_res = px;
            OP_OMUL: comb_res = po;
            OP_NONE: comb_res = '0;
            default: comb_res = '0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        ost_e         st_q;
        logic [W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q  <= ST_IDLE;
                res_q <= '0;
            end else begin
                unique case (st_q)
                    ST_IDLE: st_q <= in_valid ? ST_HOLD : ST_IDLE;
                    ST_HOLD: st_q <= in_valid ? ST_HOLD : ST_IDLE;
                    default: st_q <= ST_IDLE;
                endcase
                if (in_valid) res_q <= comb_res;
            end
        end

        always_comb begin
            out_valid = (st_q == ST_HOLD);
            result    = res_q;
        end

        // R3 R4
        xor_within_or_chk: assert property (@(posedge clk) disable iff (rst)
            (px & ~po) == '0);

        // R5
        none_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 2'b11) |=> (result == '0));

        // R6
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(result)));

        // R8
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (!out_valid && result == '0));
    end else begin : g_comb
        always_comb begin
            out_valid = in_valid;
            result    = comb_res;
        end
    end
endmodule

// File: tb/bmx_unit_tb.sv
module bmx_unit_tb;
    localparam int ROWS = 8;
    localparam int W = 64;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp;
    } vec_t;

    localparam logic [W-1:0] IDM = 64'h8040201008040201;
    localparam logic [W-1:0] PAT = 64'h0123456789ABCDEF;
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b00, IDM, PAT, IDM},
        '{2'b00, 64'h00000000000000FF, 64'h0, 64'h0101010101010101},
        '{2'b00, 64'h0101010101010101, '1, 64'h00000000000000FF},
        '{2'b00, 64'h0000000000000080, 64'h0, 64'h0100000000000000},
        '{2'b00, 64'h8000000000000000, PAT, 64'h8000000000000000},
        '{2'b01, PAT, IDM, PAT},
        '{2'b01, IDM, PAT, PAT},
        '{2'b01, '1, '1, 64'h0},
        '{2'b01, 64'h0, PAT, 64'h0},
        '{2'b10, PAT, IDM, PAT},
        '{2'b10, '1, '1, '1},
        '{2'b10, 64'h00000000000000FF, 64'h0000000000000001, 64'h0000000000000001},
        '{2'b11, '1, '1, 64'h0},
        '{2'b11, PAT, IDM, 64'h0}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic [W-1:0] opnd_a, opnd_b;
    logic [W-1:0] res_r, res_c;
    logic         ov_r, ov_c;
    int           n_chk = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    bmx_unit #(.ROWS(ROWS), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(res_r), .out_valid(ov_r)
    );

    bmx_unit #(.ROWS(ROWS), .REG_OUT(1'b0)) u_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(res_c), .out_valid(ov_c)
    );

    function automatic logic [W-1:0] ref_fn(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < ROWS; i++) begin
            for (int j = 0; j < ROWS; j++) begin
                logic x, o;
                x = 1'b0;
                o = 1'b0;
                for (int m = 0; m < ROWS; m++) begin
                    x = x ^ (a[i*ROWS+m] & b[m*ROWS+j]);
                    o = o | (a[i*ROWS+m] & b[m*ROWS+j]);
                end
                case (op)
                    2'b00: r[j*ROWS+i] = a[i*ROWS+j];
                    2'b01: r[i*ROWS+j] = x;
                    2'b10: r[i*ROWS+j] = o;
                    default: r[i*ROWS+j] = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(logic [1:0] op);
        case (op)
            2'b00: return "R1";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(logic v, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        in_valid = v;
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] held, ra, rb;
        logic [1:0]   rop;
        rst = 1'b1;
        in_valid = 1'b0;
        op_sel = 2'b00;
        opnd_a = '0;
        opnd_b = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset result", res_r, '0);
        check("R8 reset valid", {63'd0, ov_r}, 64'd0);
        rst = 1'b0;

        // Table walk, registered and direct paths
        for (int n = 0; n < NV; n++) begin
            apply(1'b1, VECS[n].op, VECS[n].a, VECS[n].b);
            #1;
            check({tag_of(VECS[n].op), " R9 direct"}, res_c, VECS[n].exp);
            check("R9 direct valid", {63'd0, ov_c}, 64'd1);
            @(negedge clk);
            check({tag_of(VECS[n].op), " R6 registered"}, res_r, VECS[n].exp);
            check("R6 valid", {63'd0, ov_r}, 64'd1);
        end

        // R2: transpose ignores opnd_b
        apply(1'b1, 2'b00, PAT, 64'h0);
        @(negedge clk);
        held = res_r;
        apply(1'b1, 2'b00, PAT, '1);
        @(negedge clk);
        check("R2 b ignored", res_r, held);
        check("R2 b ignored ref", res_r, ref_fn(2'b00, PAT, 64'h0));

        // R7: in_valid low holds result and drops valid
        held = res_r;
        apply(1'b0, 2'b01, '1, IDM);
        @(negedge clk);
        check("R7 hold result", res_r, held);
        check("R7 valid low", {63'd0, ov_r}, 64'd0);
        #1;
        check("R9 direct valid low", {63'd0, ov_c}, 64'd0);
        apply(1'b0, 2'b10, IDM, IDM);
        @(negedge clk);
        check("R7 hold second", res_r, held);

        // R6: back-to-back after idle
        apply(1'b1, 2'b10, '1, IDM);
        @(negedge clk);
        check("R6 after idle", res_r, '1);

        // Random operands against the requirement formulas
        for (int n = 0; n < 300; n++) begin
            ra  = {$urandom(), $urandom()};
            rb  = {$urandom(), $urandom()};
            rop = 2'(n % 4);
            apply(1'b1, rop, ra, rb);
            #1;
            check({tag_of(rop), " random direct"}, res_c, ref_fn(rop, ra, rb));
            @(negedge clk);
            check({tag_of(rop), " random registered"}, res_r, ref_fn(rop, ra, rb));
        end

        // R8: synchronous reset while a result is held
        apply(1'b1, 2'b01, PAT, IDM);
        @(negedge clk);
        check("R8 pre-reset", res_r, PAT);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run result", res_r, '0);
        check("R8 mid-run valid", {63'd0, ov_r}, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule